// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level Interrupt

This block buffers received bytes between a serial receiver and a host. The receiver pushes a byte with a write strobe. The host pulls the oldest byte with a read strobe, and that byte appears on the read data port one clock later. A small control register chooses how full the queue must be before the receive interrupt is raised. It also carries an enable bit and a self-clearing flush bit. A further bit is stored for software compatibility but has no effect on the queue.

The fill count is always visible. The interrupt is a combinational compare of that count against the decoded threshold, so it rises and falls in the same cycle as the count. A write while the queue is full is dropped and recorded in a sticky overrun flag.

Top module: `rx_fifo_trig`

## Requirements
- R1: After reset, count is 0, irq is 0, overrun is 0, rd_data is 0 and ctrl_q is 0.
- R2: Bytes leave in the order they were accepted. rd_data shows the popped byte from the cycle after the rd_en cycle and holds it until the next successful read.
- R3: An accepted write adds one to count and a read of a non-empty queue subtracts one. A write and a read in the same cycle on a queue that is neither empty nor full leave count unchanged. count never exceeds DEPTH (16).
- R4: A write while count is 16 is dropped, leaves count at 16 and sets overrun. overrun stays set until a flush or reset.
- R5: A read while count is 0 leaves rd_data and count unchanged.
- R6: With ctrl bit 0 set, ctrl bits 7:6 select the threshold: 00 gives 1, 01 gives 4, 10 gives 8, 11 gives 14. irq is 1 exactly while count is at or above the threshold.
- R7: With ctrl bit 0 clear, the threshold is 1 whatever bits 7:6 hold.
- R8: A control write with bit 1 set empties the queue and clears overrun by the next cycle. This takes precedence over a write in the same cycle. Bit 1 reads back as 0.
- R9: ctrl bit 3 is stored and reads back on ctrl_q[3] but changes no behaviour. ctrl_q bits 5:4 and 2:1 always read 0.
- R10: irq falls in the same cycle that a read brings count below the threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Receiver push strobe |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Host pop strobe |
| rd_data | output | 8 | Last popped byte |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write value |
| ctrl_q | output | 8 | Control register readback |
| count | output | 5 | Current fill level, 0 to 16 |
| irq | output | 1 | Fill level at or above threshold |
| overrun | output | 1 | Sticky dropped-write flag |

## Verification
The bench sweeps all four threshold codes and probes each edge one byte below and at the level. An off-by-one compare would raise irq a byte early or late, and a wrong decode would pick the wrong level. It also fills past capacity, reads an empty queue, and flushes in the same cycle as a push. A faulty design would wrap the count, overwrite the oldest byte, disturb rd_data, or keep the pushed byte after the flush. It writes the DMA bit and the reserved bits and checks that only readback changes, and it uses concurrent push and pop to catch a count that drifts.

// File: rtl/rx_fifo_trig.sv
module rx_fifo_trig #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [W-1:0]  wr_data,
  input  logic          rd_en,
  output logic [W-1:0]  rd_data,
  input  logic          ctrl_we,
  input  logic [7:0]    ctrl_wdata,
  output logic [7:0]    ctrl_q,
  output logic [CW-1:0] count,
  output logic          irq,
  output logic          overrun
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic          en, dma;
  logic [1:0]    lvl;
  logic [CW-1:0] thr;

  wire full  = (count == CW'(DEPTH));
  wire empty = (count == '0);
  wire flush = ctrl_we & ctrl_wdata[1];
  wire push  = wr_en & ~full;
  wire pop   = rd_en & ~empty;

  assign ctrl_q = {lvl, 2'b00, dma, 2'b00, en};

  always_comb begin
    thr = CW'(1);
    if (en)
      case (lvl)
        2'd0: thr = CW'(1);
        2'd1: thr = CW'(4);
        2'd2: thr = CW'(8);
        default: thr = CW'(14);
      endcase
  end

  assign irq = (count >= thr);

  always_ff @(posedge clk)
    if (push && !flush) mem[wp] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; count <= '0; overrun <= 1'b0;
      rd_data <= '0; en <= 1'b0; dma <= 1'b0; lvl <= 2'd0;
    end else begin
      if (ctrl_we) begin
        en  <= ctrl_wdata[0];
        dma <= ctrl_wdata[3];
        lvl <= ctrl_wdata[7:6];
      end
      if (flush) begin
        wp <= '0; rp <= '0; count <= '0; overrun <= 1'b0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop) begin
          rd_data <= mem[rp];
          rp <= rp + 1'b1;
        end
        case ({push, pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
        if (wr_en && full) overrun <= 1'b1;
      end
    end
  end
endmodule

module rx_fifo_trig_chk #(
  parameter int W = 8,
  parameter int DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          ctrl_we,
  input logic [7:0]    ctrl_wdata,
  input logic [7:0]    ctrl_q,
  input logic [W-1:0]  rd_data,
  input logic [CW-1:0] count,
  input logic          irq,
  input logic          overrun
);
  wire fl = ctrl_we & ctrl_wdata[1];

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  assert_full_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CW'(DEPTH) && wr_en && !rd_en && !fl) |=> (count == CW'(DEPTH) && overrun));

  assert_overrun_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !fl) |=> overrun);

  assert_empty_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && rd_en && !wr_en && !fl) |=> ($stable(rd_data) && count == '0));

  assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> (count == '0 && !overrun));

  assert_disabled_thr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[0] |-> (irq == (count != '0)));
endmodule

bind rx_fifo_trig rx_fifo_trig_chk #(.W(W), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .ctrl_we(ctrl_we),
  .ctrl_wdata(ctrl_wdata), .ctrl_q(ctrl_q), .rd_data(rd_data), .count(count),
  .irq(irq), .overrun(overrun)
);

// File: tb/test_rx_fifo_trig.sv
module test_rx_fifo_trig;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0, ctrl_we = 0;
  logic [7:0] wr_data = 0, ctrl_wdata = 0, rd_data, ctrl_q;
  logic [4:0] count;
  logic irq, overrun;

  rx_fifo_trig i_rx_fifo_trig (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_bad = 0, mcnt = 0, pend = 0;
  bit movr = 0;
  logic [7:0] mcfg = 0, last = 0;
  logic [7:0] q[$];

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int thr_of(logic [7:0] c);
    if (!c[0]) return 1;
    case (c[7:6]) 2'd0: return 1; 2'd1: return 4; 2'd2: return 8; default: return 14; endcase
  endfunction

  task automatic state(string req);
    chk({req, " count"}, count, mcnt);
    chk({req, " irq"}, irq, int'(mcnt >= thr_of(mcfg)));
    chk({req, " overrun"}, overrun, movr);
  endtask

  task automatic wr(logic [7:0] b);
    @(negedge clk); wr_en = 1; wr_data = b;
    @(posedge clk); #1 wr_en = 0;
    if (mcnt < 16) begin q.push_back(b); mcnt++; end else movr = 1;
  endtask

  task automatic rd();
    @(negedge clk); rd_en = 1;
    @(posedge clk); #1 rd_en = 0;
    if (mcnt > 0) begin pend++; mcnt--; end
  endtask

  task automatic rdwr(logic [7:0] b);
    @(negedge clk); rd_en = 1; wr_en = 1; wr_data = b;
    @(posedge clk); #1 rd_en = 0; wr_en = 0;
    pend++; q.push_back(b);
  endtask

  task automatic ctl(logic [7:0] v);
    @(negedge clk); ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); #1 ctrl_we = 0;
    mcfg = v;
    if (v[1]) begin q.delete(); mcnt = 0; movr = 0; end
  endtask

  always @(negedge clk)
    if (pend > 0) begin
      pend--;
      last = q.pop_front();
      chk("R2 order", rd_data, last);
    end

  initial begin
    int timeout = 0;
    while (timeout < 100000) begin @(posedge clk); timeout++; end
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=done", timeout);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    state("R1");
    chk("R1 rd_data", rd_data, 0);
    chk("R1 ctrl_q", ctrl_q, 0);

    ctl(8'h01);
    wr(8'h11); wr(8'h22); wr(8'h33);
    state("R3 three writes");
    rd(); rd(); rd();
    @(negedge clk);
    state("R3 drained");

    rd(); @(negedge clk);
    chk("R5 rd_data held", rd_data, 8'h33);
    state("R5 empty read");

    for (int c = 0; c < 4; c++) begin
      ctl(8'h03 | 8'(c << 6));
      for (int i = 0; i < thr_of(mcfg) - 1; i++) wr(8'(c * 16 + i));
      @(negedge clk); state("R6 below level");
      wr(8'hA0 + 8'(c)); @(negedge clk); state("R6 at level");
      rd(); @(negedge clk); state("R10 drop below");
    end

    ctl(8'hC2);
    wr(8'h5A); @(negedge clk);
    state("R7 disabled threshold");
    chk("R7 irq", irq, 1);

    ctl(8'h03);
    for (int i = 0; i < 5; i++) wr(8'h40 + 8'(i));
    rdwr(8'h77); rdwr(8'h78); @(negedge clk);
    state("R3 concurrent rd wr");
    for (int i = 0; i < 5; i++) rd();

    ctl(8'h03);
    for (int i = 0; i < 17; i++) wr(8'h60 + 8'(i));
    @(negedge clk); state("R4 full drop");
    chk("R4 overrun", overrun, 1);
    rd(); rd(); @(negedge clk);
    state("R4 sticky");
    for (int i = 0; i < 14; i++) rd();
    @(negedge clk); state("R4 drained");

    ctl(8'hF9); @(negedge clk);
    chk("R9 readback", ctrl_q, 8'hC9);
    for (int i = 0; i < 13; i++) wr(8'h80 + 8'(i));
    @(negedge clk); state("R9 dma below 14");
    wr(8'h8D); @(negedge clk); state("R9 dma at 14");

    @(negedge clk); ctrl_we = 1; ctrl_wdata = 8'h03; wr_en = 1; wr_data = 8'hEE;
    @(posedge clk); #1 ctrl_we = 0; wr_en = 0;
    mcfg = 8'h03; q.delete(); mcnt = 0; movr = 0;
    @(negedge clk);
    state("R8 flush beats write");
    chk("R8 bit1 reads 0", ctrl_q, 8'h01);
    wr(8'h9C); rd(); @(negedge clk);
    state("R8 after flush");

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule